// File: doc/BRIEF.md
# Multi-Lane Serial Shift Engine

This block turns a parallel transmit word into a stream of bit groups on one, two or four serial output lanes. In the same steps it gathers bits from the matching serial input lanes into a receive word. One shift step happens on each qualified clock-enable tick. Each step moves a group of up to four bits out and captures the same number of bits in.

Configuration inputs set the following for each word:
- the bit order, either least significant first or most significant first;
- the word length, from 1 to 16 bits;
- the lane count;
- the level driven on idle lines;
- an optional inversion of the outgoing data;
- how a shift-control input qualifies transfers.

The settings are captured at the moment a word is accepted. They stay fixed until that word completes, so software can reprogram them while a word is in flight.

Words come in on a valid/ready handshake. The finished receive word appears together with a one-clock valid strobe. The shift-control input can block transfers entirely, allow them only while it is high, allow them only while it is low, or allow one new word per level change.

Top module: `lane_shift_engine`

## Requirements
- R1: With `cfgMsbFirst`=0, step s places word bits s*L+j on lane j, where L is the lane count. The first step starts at bit 0.
- R2: With `cfgMsbFirst`=1, lane j of step s carries word bit N-1-(s*L+j), where N is the word length. The first bit out is bit N-1.
- R3: The word length is N = `cfgWordLen`+1. Only bits [N-1:0] of `txData` are sent. Bits of `rxData` at N and above read 0.
- R4: `cfgLanes` sets the lane count: 0 or 1 gives one lane (`serOut[0]`/`serIn[0]`), 2 gives lanes [1:0], and 3 gives lanes [3:0]. A word takes ceil(N/L) steps.
- R5: When N is not a multiple of L, the last step carries only the remaining bits. Its unused output lanes drive the idle level, and unused receive bits stay 0.
- R6: While no word is in flight, every `serOut` line equals `cfgIdleLevel`. During a word, lanes above the lane count drive the idle level captured at acceptance.
- R7: With `cfgInvert`=1, every data-carrying lane outputs the complement of the word bit. Idle-level lanes are never inverted.
- R8: With `cfgCtlMode`=0, `txReady` stays 0 and no word starts.
- R9: With `cfgCtlMode`=1, words start and steps advance only while `shiftCtl` is 1. With `cfgCtlMode`=2, this happens only while `shiftCtl` is 0. A tick at the wrong level leaves the outputs on the same step.
- R10: With `cfgCtlMode`=3, a word may start only after a change of `shiftCtl` since the previous start or reset, and steps ignore the level. A change in the same cycle as a start is kept for the next word.
- R11: `txReady` is 1 only when the engine is idle and the mode qualifies. A word is accepted on `txValid`&&`txReady`. All settings are captured then and held for the whole word.
- R12: `rxValid` pulses for exactly one clock, in the cycle after the tick that completes the final step. `rxData` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgMsbFirst | input | 1 | 1: most significant bit first |
| cfgWordLen | input | 4 | Word length minus one |
| cfgLanes | input | 2 | Lane-count code (0/1: one, 2: two, 3: four) |
| cfgIdleLevel | input | 1 | Level on lines that carry no data |
| cfgInvert | input | 1 | Invert outgoing data bits |
| cfgCtlMode | input | 2 | Shift-control qualification mode |
| txData | input | 16 | Word to send |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Engine can accept a word |
| rxData | output | 16 | Last completed receive word |
| rxValid | output | 1 | One-clock completion strobe |
| shiftTick | input | 1 | Shift step enable |
| shiftCtl | input | 1 | Shift-control input |
| serIn | input | 4 | Serial input lanes |
| serOut | output | 4 | Serial output lanes |

## Verification
In edge mode, a change of `shiftCtl` can arrive in the very cycle a word is accepted. Accepting the word consumes the stored change, while the new change must arm the next word. The bench provokes this by toggling `shiftCtl` on the accepting edge. It then checks that `txReady` returns at the end of that word with no further change, and that it stays low after a following word started without one. A second collision is between a live configuration change and a word in flight. The bench scrambles the configuration inputs right after acceptance and compares every step against the settings it offered.

// File: rtl/lse_pkg.sv
package lse_pkg;

  localparam int MAX_LANES = 4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_HIGH = 2'd1,
    MODE_LOW  = 2'd2,
    MODE_EDGE = 2'd3
  } ctlMode_e;

  typedef struct packed {
    logic       msbFirst;
    logic [1:0] laneCode;
    logic       idleLevel;
    logic       invert;
    ctlMode_e   mode;
  } shiftCfg_t;

  typedef struct packed {
    logic load;
    logic step;
    logic done;
  } shiftStrb_t;

  function automatic int laneCount(input logic [1:0] code);
    case (code)
      2'd3:    return 4;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/lse_ctrl.sv
module lse_ctrl
  import lse_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftCfg_t        cfgLive,
  input  logic [LEN_W-1:0] wordLenLive,
  input  logic             txValid,
  input  logic             shiftTick,
  input  logic             shiftCtl,
  output logic             txReady,
  output shiftStrb_t       strb,
  output logic             busy,
  output logic [LEN_W+1:0] bitPos,
  output shiftCfg_t        cfgHeld,
  output logic [LEN_W-1:0] wordLenHeld
);

  localparam int POS_W = LEN_W + 2;

  logic             ctlPrev;
  logic             edgeArmed;
  logic             edgeNow;
  logic             startOk;
  logic             stepOk;
  logic [POS_W-1:0] wordBits;
  logic [POS_W-1:0] nextPos;

  assign edgeNow = shiftCtl ^ ctlPrev;

  // start qualification uses the live mode, stepping uses the captured one
  always_comb begin
    case (cfgLive.mode)
      MODE_HIGH: startOk = shiftCtl;
      MODE_LOW:  startOk = !shiftCtl;
      MODE_EDGE: startOk = edgeArmed;
      default:   startOk = 1'b0;
    endcase
    case (cfgHeld.mode)
      MODE_HIGH: stepOk = shiftCtl;
      MODE_LOW:  stepOk = !shiftCtl;
      MODE_EDGE: stepOk = 1'b1;
      default:   stepOk = 1'b0;
    endcase
  end

  assign wordBits = POS_W'(wordLenHeld) + POS_W'(1);
  assign nextPos  = bitPos + POS_W'(laneCount(cfgHeld.laneCode));

  assign txReady   = !busy && startOk;
  assign strb.load = txValid && txReady;
  assign strb.step = busy && shiftTick && stepOk;
  assign strb.done = strb.step && (nextPos >= wordBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlPrev     <= 1'b0;
      edgeArmed   <= 1'b0;
      busy        <= 1'b0;
      bitPos      <= '0;
      cfgHeld     <= '0;
      wordLenHeld <= '0;
    end else begin
      ctlPrev   <= shiftCtl;
      // a start consumes the stored change; a change in the same cycle re-arms
      edgeArmed <= (edgeArmed && !strb.load) || edgeNow;
      if (strb.load) begin
        busy        <= 1'b1;
        bitPos      <= '0;
        cfgHeld     <= cfgLive;
        wordLenHeld <= wordLenLive;
      end else if (strb.done) begin
        busy   <= 1'b0;
        bitPos <= '0;
      end else if (strb.step) begin
        bitPos <= nextPos;
      end
    end
  end

endmodule

// File: rtl/lse_datapath.sv
module lse_datapath
  import lse_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  shiftStrb_t            strb,
  input  logic                  busy,
  input  logic [LEN_W+1:0]      bitPos,
  input  logic                  msbHeld,
  input  logic [1:0]            laneCodeHeld,
  input  logic                  invertHeld,
  input  logic                  idleHeld,
  input  logic [LEN_W-1:0]      wordLenHeld,
  input  logic                  idleLive,
  input  logic [(1<<LEN_W)-1:0] txData,
  input  logic [MAX_LANES-1:0]  serIn,
  output logic [MAX_LANES-1:0]  serOut,
  output logic [(1<<LEN_W)-1:0] rxData,
  output logic                  rxValid
);

  localparam int DATA_W = 1 << LEN_W;
  localparam int POS_W  = LEN_W + 2;

  logic [DATA_W-1:0]    txWord;
  logic [DATA_W-1:0]    rxAcc;
  logic [DATA_W-1:0]    rxNext;
  logic [POS_W-1:0]     wordBits;
  logic [2:0]           lanes;
  logic [MAX_LANES-1:0] laneLive;
  logic [LEN_W-1:0]     lanePos [MAX_LANES];

  assign wordBits = POS_W'(wordLenHeld) + POS_W'(1);
  assign lanes    = 3'(laneCount(laneCodeHeld));

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [POS_W-1:0] idx;
    assign idx         = bitPos + POS_W'(j);
    assign laneLive[j] = busy && (3'(j) < lanes) && (idx < wordBits);
    assign lanePos[j]  = msbHeld ? LEN_W'(wordBits - POS_W'(1) - idx) : LEN_W'(idx);
    assign serOut[j]   = laneLive[j] ? (txWord[lanePos[j]] ^ invertHeld)
                                     : (busy ? idleHeld : idleLive);
  end

  always_comb begin
    rxNext = rxAcc;
    for (int j = 0; j < MAX_LANES; j++) begin
      if (laneLive[j]) rxNext[lanePos[j]] = serIn[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord  <= '0;
      rxAcc   <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.done;
      if (strb.load) begin
        txWord <= txData;
        rxAcc  <= '0;
      end else if (strb.step) begin
        rxAcc <= rxNext;
      end
      if (strb.done) rxData <= rxNext;
    end
  end

endmodule

// File: rtl/lane_shift_engine.sv
module lane_shift_engine
  import lse_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgMsbFirst,
  input  logic [LEN_W-1:0]      cfgWordLen,
  input  logic [1:0]            cfgLanes,
  input  logic                  cfgIdleLevel,
  input  logic                  cfgInvert,
  input  logic [1:0]            cfgCtlMode,
  input  logic [(1<<LEN_W)-1:0] txData,
  input  logic                  txValid,
  output logic                  txReady,
  output logic [(1<<LEN_W)-1:0] rxData,
  output logic                  rxValid,
  input  logic                  shiftTick,
  input  logic                  shiftCtl,
  input  logic [MAX_LANES-1:0]  serIn,
  output logic [MAX_LANES-1:0]  serOut
);

  localparam int DATA_W = 1 << LEN_W;

  shiftCfg_t        cfgLive;
  shiftCfg_t        cfgHeld;
  shiftStrb_t       strb;
  logic             busy;
  logic [LEN_W+1:0] bitPos;
  logic [LEN_W-1:0] wordLenHeld;

  assign cfgLive.msbFirst  = cfgMsbFirst;
  assign cfgLive.laneCode  = cfgLanes;
  assign cfgLive.idleLevel = cfgIdleLevel;
  assign cfgLive.invert    = cfgInvert;
  assign cfgLive.mode      = ctlMode_e'(cfgCtlMode);

  lse_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLive     (cfgLive),
    .wordLenLive (cfgWordLen),
    .txValid     (txValid),
    .shiftTick   (shiftTick),
    .shiftCtl    (shiftCtl),
    .txReady     (txReady),
    .strb        (strb),
    .busy        (busy),
    .bitPos      (bitPos),
    .cfgHeld     (cfgHeld),
    .wordLenHeld (wordLenHeld)
  );

  lse_datapath #(.LEN_W(LEN_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busy         (busy),
    .bitPos       (bitPos),
    .msbHeld      (cfgHeld.msbFirst),
    .laneCodeHeld (cfgHeld.laneCode),
    .invertHeld   (cfgHeld.invert),
    .idleHeld     (cfgHeld.idleLevel),
    .wordLenHeld  (wordLenHeld),
    .idleLive     (cfgIdleLevel),
    .txData       (txData),
    .serIn        (serIn),
    .serOut       (serOut),
    .rxData       (rxData),
    .rxValid      (rxValid)
  );

endmodule

// File: rtl/lse_checker.sv
module lse_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic [1:0]        cfgCtlMode,
  input logic              cfgIdleLevel,
  input logic              shiftCtl,
  input logic [3:0]        serOut
);

  p_off_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCtlMode == 2'd0) |-> !txReady);

  p_high_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCtlMode == 2'd1 && !shiftCtl) |-> !txReady);

  p_low_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCtlMode == 2'd2 && shiftCtl) |-> !txReady);

  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (serOut == {4{cfgIdleLevel}}));

  p_load_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_rx_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

endmodule

bind lane_shift_engine lse_checker #(.DATA_W(DATA_W)) u_lse_checker (.*);

// File: tb/test_lane_shift_engine.sv
`timescale 1ns/1ps
module test_lane_shift_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgMsbFirst, cfgIdleLevel, cfgInvert;
  logic [3:0]  cfgWordLen;
  logic [1:0]  cfgLanes, cfgCtlMode;
  logic [15:0] txData, rxData;
  logic        txValid, txReady, rxValid, shiftTick, shiftCtl;
  logic [3:0]  serIn, serOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lane_shift_engine i_lane_shift_engine (
    .clk(clk), .rstN(rstN), .cfgMsbFirst(cfgMsbFirst), .cfgWordLen(cfgWordLen),
    .cfgLanes(cfgLanes), .cfgIdleLevel(cfgIdleLevel), .cfgInvert(cfgInvert),
    .cfgCtlMode(cfgCtlMode), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .shiftTick(shiftTick), .shiftCtl(shiftCtl),
    .serIn(serIn), .serOut(serOut)
  );

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      finishRun();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lanesOf(input logic [1:0] code);
    return (code == 2'd3) ? 4 : (code == 2'd2) ? 2 : 1;
  endfunction

  function automatic int bitAt(input logic msb, input int n, input int idx);
    return msb ? (n - 1 - idx) : idx;
  endfunction

  function automatic logic [3:0] expGroup(input logic [15:0] word, input logic msb,
      input logic [3:0] wl, input logic [1:0] code, input logic inv, input logic idle,
      input int s);
    logic [3:0] r;
    int n, l;
    n = int'(wl) + 1;
    l = lanesOf(code);
    for (int j = 0; j < 4; j++) begin
      if (j < l && s*l + j < n) r[j] = word[bitAt(msb, n, s*l + j)] ^ inv;
      else                      r[j] = idle;
    end
    return r;
  endfunction

  task automatic xfer(input logic [15:0] word, input logic msb, input logic [3:0] wl,
      input logic [1:0] code, input logic inv, input logic idle,
      input bit scramble, input bit gaps, input bit toggleAtLoad, input string tag);
    int n, l, steps;
    logic [15:0] expRx;
    logic [3:0]  bits;
    n = int'(wl) + 1;
    l = lanesOf(code);
    steps = (n + l - 1) / l;
    expRx = '0;
    @(negedge clk);
    cfgMsbFirst = msb; cfgWordLen = wl; cfgLanes = code;
    cfgInvert = inv; cfgIdleLevel = idle; txData = word; txValid = 1'b1;
    #1;
    chk({tag, " R11 ready before load"}, 32'(txReady), 32'd1);
    if (toggleAtLoad) shiftCtl = !shiftCtl;
    @(posedge clk); @(negedge clk);
    txValid = 1'b0;
    #1;
    chk({tag, " R11 not ready while busy"}, 32'(txReady), 32'd0);
    if (scramble) begin
      // settings captured at load must survive live changes (R11)
      cfgMsbFirst = 1'($urandom); cfgWordLen = 4'($urandom);
      cfgLanes = 2'($urandom); cfgInvert = 1'($urandom);
    end
    for (int s = 0; s < steps; s++) begin
      if (gaps && $urandom_range(0, 3) == 0) begin
        shiftTick = 1'b0;
        @(posedge clk); @(negedge clk);
      end
      if (gaps && (cfgCtlMode == 2'd1 || cfgCtlMode == 2'd2) && $urandom_range(0, 3) == 0) begin
        shiftCtl = !shiftCtl; shiftTick = 1'b1; serIn = 4'($urandom);
        @(posedge clk); @(negedge clk);
        shiftTick = 1'b0; shiftCtl = !shiftCtl;
        #1;
        chk({tag, " R9 wrong-level tick holds step"}, 32'(serOut),
            32'(expGroup(word, msb, wl, code, inv, idle, s)));
      end
      #1;
      chk({tag, " R1 R2 R4 R5 R7 step lanes"}, 32'(serOut),
          32'(expGroup(word, msb, wl, code, inv, idle, s)));
      bits = 4'($urandom);
      serIn = bits; shiftTick = 1'b1;
      for (int j = 0; j < l; j++) begin
        if (s*l + j < n) expRx[bitAt(msb, n, s*l + j)] = bits[j];
      end
      @(posedge clk); @(negedge clk);
      shiftTick = 1'b0;
    end
    #1;
    chk({tag, " R12 rxValid pulse"}, 32'(rxValid), 32'd1);
    chk({tag, " R3 R5 rxData"}, 32'(rxData), 32'(expRx));
    chk({tag, " R6 idle after word"}, 32'(serOut), 32'({4{idle}}));
    @(negedge clk); #1;
    chk({tag, " R12 pulse ends"}, 32'(rxValid), 32'd0);
    chk({tag, " R12 rxData held"}, 32'(rxData), 32'(expRx));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; cfgMsbFirst = 0; cfgWordLen = 0; cfgLanes = 0; cfgIdleLevel = 0;
    cfgInvert = 0; cfgCtlMode = 0; txData = 0; txValid = 0; shiftTick = 0;
    shiftCtl = 0; serIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R8 reset ready", 32'(txReady), 32'd0);
    chk("R6 reset serOut", 32'(serOut), 32'd0);
    chk("R12 reset rxValid", 32'(rxValid), 32'd0);
    chk("R12 reset rxData", 32'(rxData), 32'd0);

    // mode 0 blocks every start
    txValid = 1'b1; shiftCtl = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk("R8 mode off ready", 32'(txReady), 32'd0);
      chk("R8 mode off no start", 32'(serOut), 32'd0);
    end
    txValid = 1'b0;
    cfgIdleLevel = 1'b1; #1;
    chk("R6 idle level one", 32'(serOut), 32'hF);
    cfgIdleLevel = 1'b0;

    // mode 1 level qualification
    cfgCtlMode = 2'd1; shiftCtl = 1'b0; #1;
    chk("R9 high mode blocked at low", 32'(txReady), 32'd0);
    shiftCtl = 1'b1; #1;
    chk("R9 high mode ready at high", 32'(txReady), 32'd1);

    xfer(16'hA5C3, 0, 4'd15, 2'd0, 0, 0, 0, 1, 0, "R1 lsb single");
    xfer(16'hA5C3, 1, 4'd15, 2'd0, 0, 0, 0, 0, 0, "R2 msb single");
    xfer(16'hFFFF, 0, 4'd0,  2'd0, 0, 0, 0, 0, 0, "R3 one bit");
    xfer(16'h1234, 1, 4'd4,  2'd2, 0, 0, 0, 0, 0, "R5 dual partial");
    xfer(16'hBEEF, 1, 4'd6,  2'd3, 1, 0, 0, 0, 0, "R7 quad inverted");
    xfer(16'h0F0F, 0, 4'd15, 2'd3, 0, 1, 0, 0, 0, "R4 quad idle one");
    xfer(16'h5555, 0, 4'd9,  2'd1, 1, 1, 0, 0, 0, "R4 code one single");
    xfer(16'h8001, 0, 4'd2,  2'd3, 0, 1, 0, 0, 0, "R6 quad lane above length");

    // mode 2
    @(negedge clk);
    cfgCtlMode = 2'd2; shiftCtl = 1'b1; #1;
    chk("R9 low mode blocked at high", 32'(txReady), 32'd0);
    shiftCtl = 1'b0; #1;
    chk("R9 low mode ready at low", 32'(txReady), 32'd1);
    xfer(16'h3C96, 1, 4'd11, 2'd2, 0, 0, 0, 1, 0, "R9 low mode word");

    // mode 3: level ignored, one word per change of shiftCtl
    @(negedge clk);
    cfgCtlMode = 2'd3; #1;
    if (txReady) xfer(16'h00FF, 0, 4'd7, 2'd0, 0, 0, 0, 0, 0, "R10 consume armed");
    @(negedge clk); #1;
    chk("R10 no change no ready", 32'(txReady), 32'd0);
    shiftCtl = 1'b1;
    @(negedge clk); #1;
    chk("R10 change arms ready", 32'(txReady), 32'd1);
    xfer(16'hC3A5, 1, 4'd13, 2'd3, 0, 0, 0, 1, 1, "R10 collision word");
    #1;
    chk("R10 change at load kept", 32'(txReady), 32'd1);
    xfer(16'h7E81, 0, 4'd15, 2'd2, 1, 0, 0, 1, 0, "R10 second word");
    #1;
    chk("R10 no change after word", 32'(txReady), 32'd0);

    // random words in the level modes with live settings scrambled
    for (int it = 0; it < 200; it++) begin
      @(negedge clk);
      cfgCtlMode = ($urandom_range(0, 1) == 0) ? 2'd1 : 2'd2;
      shiftCtl = (cfgCtlMode == 2'd1);
      xfer(16'($urandom), 1'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1, 1, 0, "R11 random");
    end

    finishRun();
  end

endmodule